// File: doc/BRIEF.md
# Dual-Die Status Router

This block is the controller-side logic for a package in which two memory dies share one I/O bus and can work on different array operations at the same time. For each die it keeps a busy flag and a status byte. It routes every newly started operation to one die, chosen by the most significant bit of the row address, and passes that die the remaining row bits. It answers status commands either for one addressed die or for both dies combined. It also drives the shared ready/busy line in the way an open-drain wire would behave.

Array operations are modelled as a start pulse per die plus a busy timer whose fixed length depends on the kind of operation. Three operation kinds are supported: read, program and erase. The requester supplies the pass/fail outcome that the die will report when it finishes. If an operation is aimed at a die that is still busy, it is refused and the refusal is flagged. The other die is not affected by the refusal.

Top module: `dual_die_status_router`

## Requirements
- R1: An accepted `op_start` produces a one-cycle pulse on `die_start` in the next cycle. Bit 0 of `die_start` is pulsed when `op_row[ROW_W-1]` is 0, and bit 1 when it is 1. In that same cycle, `die_row` carries `op_row[ROW_W-2:0]`.
- R2: A die stays busy for exactly a fixed number of cycles, counted from the clock edge that accepts its operation. The count depends on `op_kind`: 2'b00 is a read (READ_CYC), 2'b01 is a program (PROG_CYC), and 2'b10 or 2'b11 is an erase (ERASE_CYC).
- R3: `ready_busy_n` is 0 whenever at least one die is busy, and 1 only when both dies are idle.
- R4: An operation aimed at a busy die is refused. `op_reject` pulses in the next cycle, no `die_start` pulse is produced, and the busy die still finishes at its original time.
- R5: An operation aimed at an idle die is accepted while the other die is busy, so both dies can be busy at once.
- R6: After command F2h, every `rd_stb` returns die 0's status byte. After command F3h, every `rd_stb` returns die 1's status byte. Die 0 owns rows 0 to 3FFFFh and die 1 owns rows 40000h to 7FFFFh.
- R7: The status byte is laid out as follows: bit 7 = `wp_n` (1 = not write-protected), bit 6 = ready (1 = idle), bit 0 = fail flag of the last completed operation, and bits 5..1 = 0.
- R8: The `op_fail` value is captured when an operation is accepted. It appears in the die's fail bit when that operation completes. An accepted operation clears the die's fail bit until it completes.
- R9: After command 70h, `rd_stb` returns a combined byte. Its ready bit is set only when both dies are idle, and its fail bit is set if either die's fail flag is set.
- R10: A status mode persists across any number of `rd_stb` pulses until a new command is latched. After any command other than 70h, F2h or F3h, `rd_stb` gives no `rd_valid`.
- R11: After reset, both dies are idle with their fail flags clear, `ready_busy_n` is 1, and `die_start`, `op_reject` and `rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect level reported in status bit 7 |
| cmd_we | input | 1 | Latch `cmd_byte` as a command |
| cmd_byte | input | 8 | Command code |
| rd_stb | input | 1 | Read strobe for the status byte |
| rd_valid | output | 1 | `rd_data` holds a status byte for the previous strobe |
| rd_data | output | 8 | Status byte returned |
| op_start | input | 1 | Request to start an array operation |
| op_kind | input | 2 | Operation kind: 00 read, 01 program, 1x erase |
| op_row | input | ROW_W | Row address of the operation |
| op_fail | input | 1 | Outcome that the operation reports when it completes |
| die_start | output | 2 | One-hot start pulse routed to a die |
| die_row | output | ROW_W-1 | Row within the chosen die |
| op_reject | output | 1 | Request was refused because the target die is busy |
| ready_busy_n | output | 1 | Combined ready/busy line, low while any die is busy |

## Verification
The bench builds the block with timer lengths of 4, 12 and 30 cycles for read, program and erase. These lengths are short enough that every busy window can be measured edge by edge. They are also far enough apart that one die finishes a program well inside the other die's erase. This lets the bench test per-die status during true overlap, a refusal issued in the middle of an operation, and the moment the combined line is released. The 19-bit row width matches the die boundary at 40000h.

// File: rtl/nand_dsr_pkg.sv
package nand_dsr_pkg;

  typedef enum logic [1:0] {
    SM_NONE = 2'd0,
    SM_COMB = 2'd1,
    SM_DIE0 = 2'd2,
    SM_DIE1 = 2'd3
  } stat_mode_e;

  localparam logic [7:0] CMD_STAT_ALL  = 8'h70;
  localparam logic [7:0] CMD_STAT_DIE0 = 8'hF2;
  localparam logic [7:0] CMD_STAT_DIE1 = 8'hF3;

  localparam logic [1:0] KIND_READ = 2'b00;
  localparam logic [1:0] KIND_PROG = 2'b01;

  // Pack a status byte: [7]=not protected, [6]=ready, [0]=fail
  function automatic logic [7:0] pack_status(input logic ready,
                                             input logic fail,
                                             input logic wp_n);
    return {wp_n, ready, 5'b00000, fail};
  endfunction

  function automatic stat_mode_e decode_cmd(input logic [7:0] code);
    case (code)
      CMD_STAT_ALL:  return SM_COMB;
      CMD_STAT_DIE0: return SM_DIE0;
      CMD_STAT_DIE1: return SM_DIE1;
      default:       return SM_NONE;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dsr_die_tracker.sv
module dsr_die_tracker
  import nand_dsr_pkg::*;
#(
  parameter int unsigned READ_CYC  = 25,
  parameter int unsigned PROG_CYC  = 200,
  parameter int unsigned ERASE_CYC = 350
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] kind,
  input  logic       fail_in,
  output logic       busy,
  output logic       fail
);
  localparam int unsigned MAX_LEN = max3(READ_CYC, PROG_CYC, ERASE_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  function automatic logic [CNT_W-1:0] op_len(input logic [1:0] k);
    case (k)
      KIND_READ: return CNT_W'(READ_CYC);
      KIND_PROG: return CNT_W'(PROG_CYC);
      default:   return CNT_W'(ERASE_CYC);
    endcase
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             pend_fail;
  logic             done_evt;

  assign done_evt = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      fail      <= 1'b0;
      pend_fail <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      cnt       <= op_len(kind) - CNT_W'(1);
      fail      <= 1'b0;
      pend_fail <= fail_in;
    end else if (done_evt) begin
      busy <= 1'b0;
      fail <= pend_fail;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R4: the router must never start a die that is still busy
  p_no_start_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R2: busy only rises from a start
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R2: busy only falls once the timer has run out
  p_busy_ends_on_timer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_evt));
  // R8: a completed operation reports the captured outcome
  p_fail_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_evt) && !$past(start) |-> fail == $past(pend_fail));

endmodule

// File: rtl/dsr_status_sel.sv
module dsr_status_sel
  import nand_dsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       rd_stb,
  input  logic [1:0] busy,
  input  logic [1:0] fail,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  stat_mode_e mode;
  logic [7:0] sel_byte;

  always_comb begin
    case (mode)
      SM_COMB: sel_byte = pack_status(~|busy, |fail, wp_n);
      SM_DIE0: sel_byte = pack_status(~busy[0], fail[0], wp_n);
      SM_DIE1: sel_byte = pack_status(~busy[1], fail[1], wp_n);
      default: sel_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= SM_NONE;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      if (cmd_we) mode <= decode_cmd(cmd_byte);
      rd_valid <= rd_stb && (mode != SM_NONE);
      if (rd_stb) rd_data <= sel_byte;
    end
  end

  // R10: data is only presented in answer to a strobe
  p_valid_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_stb));
  // R6: die 0 readout mirrors die 0 busy state
  p_die0_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(mode == SM_DIE0) |-> rd_data[6] == !$past(busy[0]));
  // R6: die 1 readout mirrors die 1 busy state
  p_die1_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(mode == SM_DIE1) |-> rd_data[6] == !$past(busy[1]));
  // R9: combined readout is ready only with both dies idle
  p_comb_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(mode == SM_COMB) |-> rd_data[6] == !$past(busy[0] || busy[1]));

endmodule

// File: rtl/dual_die_status_router.sv
module dual_die_status_router
  import nand_dsr_pkg::*;
#(
  parameter int unsigned ROW_W     = 19,
  parameter int unsigned READ_CYC  = 25,
  parameter int unsigned PROG_CYC  = 200,
  parameter int unsigned ERASE_CYC = 350
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_byte,
  input  logic             rd_stb,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             op_start,
  input  logic [1:0]       op_kind,
  input  logic [ROW_W-1:0] op_row,
  input  logic             op_fail,
  output logic [1:0]       die_start,
  output logic [ROW_W-2:0] die_row,
  output logic             op_reject,
  output logic             ready_busy_n
);
  localparam int unsigned N_DIE = 2;

  logic [N_DIE-1:0] busy;
  logic [N_DIE-1:0] fail;
  logic [N_DIE-1:0] accept_vec;
  logic             tgt_die;
  logic             tgt_busy;
  logic             reject_evt;

  assign tgt_die    = op_row[ROW_W-1];
  assign tgt_busy   = busy[tgt_die];
  assign reject_evt = op_start && tgt_busy;

  always_comb begin
    accept_vec = '0;
    if (op_start && !tgt_busy) accept_vec[tgt_die] = 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < N_DIE; g++) begin : g_die
      dsr_die_tracker #(
        .READ_CYC (READ_CYC),
        .PROG_CYC (PROG_CYC),
        .ERASE_CYC(ERASE_CYC)
      ) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept_vec[g]),
        .kind   (op_kind),
        .fail_in(op_fail),
        .busy   (busy[g]),
        .fail   (fail[g])
      );

      // R1: a start pulse to a die leaves that die busy
      p_start_sets_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        die_start[g] |-> busy[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      die_start <= '0;
      die_row   <= '0;
      op_reject <= 1'b0;
    end else begin
      die_start <= accept_vec;
      op_reject <= reject_evt;
      if (|accept_vec) die_row <= op_row[ROW_W-2:0];
    end
  end

  // Open-drain style: any busy die pulls the shared line low
  assign ready_busy_n = ~|busy;

  dsr_status_sel u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_n    (wp_n),
    .cmd_we  (cmd_we),
    .cmd_byte(cmd_byte),
    .rd_stb  (rd_stb),
    .busy    (busy),
    .fail    (fail),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  // R1: at most one die is started per cycle
  p_start_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(die_start));
  // R4: a refusal never comes with a start
  p_reject_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |-> die_start == '0);
  // R4: a refusal answers a request
  p_reject_has_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_reject |-> $past(op_start));

endmodule

// File: tb/dual_die_status_router_tb.sv
module dual_die_status_router_tb;
  localparam int unsigned ROW_W = 19;
  localparam int unsigned RD_C  = 4;
  localparam int unsigned PG_C  = 12;
  localparam int unsigned ER_C  = 30;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wp_n = 1'b1;
  logic             cmd_we = 1'b0;
  logic [7:0]       cmd_byte = 8'h00;
  logic             rd_stb = 1'b0;
  logic             rd_valid;
  logic [7:0]       rd_data;
  logic             op_start = 1'b0;
  logic [1:0]       op_kind = 2'b00;
  logic [ROW_W-1:0] op_row = '0;
  logic             op_fail = 1'b0;
  logic [1:0]       die_start;
  logic [ROW_W-2:0] die_row;
  logic             op_reject;
  logic             ready_busy_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dual_die_status_router #(
    .ROW_W(ROW_W), .READ_CYC(RD_C), .PROG_CYC(PG_C), .ERASE_CYC(ER_C)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .rd_stb(rd_stb), .rd_valid(rd_valid), .rd_data(rd_data),
    .op_start(op_start), .op_kind(op_kind), .op_row(op_row), .op_fail(op_fail),
    .die_start(die_start), .die_row(die_row), .op_reject(op_reject),
    .ready_busy_n(ready_busy_n)
  );

  // Expected status byte: [7]=wp_n, [6]=ready, [0]=fail
  function automatic logic [7:0] exp_stat(input logic rdy, input logic fl, input logic wp);
    logic [7:0] b;
    b = 8'h00;
    b[7] = wp;
    b[6] = rdy;
    b[0] = fl;
    return b;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue_op(input logic [ROW_W-1:0] row, input logic [1:0] k, input logic f);
    op_start = 1'b1; op_row = row; op_kind = k; op_fail = f;
    @(negedge clk);
    op_start = 1'b0; op_fail = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    cmd_we = 1'b1; cmd_byte = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic strobe(output logic v, output logic [7:0] d);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_valid;
    d = rd_data;
  endtask

  task automatic read_stat(input string tag, input logic [7:0] c, input logic [7:0] exp);
    logic v;
    logic [7:0] d;
    send_cmd(c);
    strobe(v, d);
    chk({tag, " valid"}, 32'(v), 32'(1));
    chk(tag, 32'(d), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R11 ready_busy_n", 32'(ready_busy_n), 32'(1));
    chk("R11 die_start", 32'(die_start), 32'(0));
    chk("R11 op_reject", 32'(op_reject), 32'(0));
    chk("R11 rd_valid", 32'(rd_valid), 32'(0));
    read_stat("R11 R7 die0 idle", 8'hF2, exp_stat(1, 0, 1));
    read_stat("R11 R7 die1 idle", 8'hF3, exp_stat(1, 0, 1));
  endtask

  task automatic t_route();
    issue_op(19'h00005, 2'b00, 1'b0);
    chk("R1 die0 start", 32'(die_start), 32'(2'b01));
    chk("R1 die0 row", 32'(die_row), 32'(5));
    chk("R3 busy low", 32'(ready_busy_n), 32'(0));
    wait_n(RD_C - 1);
    chk("R2 read last busy", 32'(ready_busy_n), 32'(0));
    wait_n(1);
    chk("R2 read done", 32'(ready_busy_n), 32'(1));
    issue_op(19'h40007, 2'b11, 1'b0);
    chk("R1 die1 start", 32'(die_start), 32'(2'b10));
    chk("R1 die1 row", 32'(die_row), 32'(7));
    wait_n(ER_C - 1);
    chk("R2 erase kind 11 last busy", 32'(ready_busy_n), 32'(0));
    wait_n(1);
    chk("R2 erase kind 11 done", 32'(ready_busy_n), 32'(1));
  endtask

  task automatic t_reject();
    issue_op(19'h00100, 2'b01, 1'b0);
    issue_op(19'h00200, 2'b10, 1'b0);
    chk("R4 reject flag", 32'(op_reject), 32'(1));
    chk("R4 no start", 32'(die_start), 32'(0));
    wait_n(PG_C - 2);
    chk("R4 R2 program last busy", 32'(ready_busy_n), 32'(0));
    wait_n(1);
    chk("R4 R2 program done on time", 32'(ready_busy_n), 32'(1));
    chk("R4 reject one cycle", 32'(op_reject), 32'(0));
  endtask

  task automatic t_concurrent();
    issue_op(19'h00010, 2'b10, 1'b0);
    issue_op(19'h40020, 2'b01, 1'b0);
    chk("R5 second die starts", 32'(die_start), 32'(2'b10));
    chk("R5 no reject", 32'(op_reject), 32'(0));
    read_stat("R6 die0 busy", 8'hF2, exp_stat(0, 0, 1));
    read_stat("R6 die1 busy", 8'hF3, exp_stat(0, 0, 1));
    read_stat("R9 both busy", 8'h70, exp_stat(0, 0, 1));
    wait_n(6);
    read_stat("R6 die1 done", 8'hF3, exp_stat(1, 0, 1));
    chk("R3 one die still busy", 32'(ready_busy_n), 32'(0));
    read_stat("R6 die0 still busy", 8'hF2, exp_stat(0, 0, 1));
    read_stat("R9 one busy", 8'h70, exp_stat(0, 0, 1));
    wait_n(ER_C);
    read_stat("R9 both idle", 8'h70, exp_stat(1, 0, 1));
    chk("R3 released", 32'(ready_busy_n), 32'(1));
  endtask

  task automatic t_fail();
    issue_op(19'h40000, 2'b01, 1'b1);
    read_stat("R8 fail hidden while busy", 8'hF3, exp_stat(0, 0, 1));
    wait_n(PG_C);
    read_stat("R8 die1 fail shown", 8'hF3, exp_stat(1, 1, 1));
    read_stat("R8 die0 unaffected", 8'hF2, exp_stat(1, 0, 1));
    read_stat("R9 combined fail", 8'h70, exp_stat(1, 1, 1));
    issue_op(19'h40001, 2'b01, 1'b0);
    read_stat("R8 fail cleared on start", 8'hF3, exp_stat(0, 0, 1));
    wait_n(PG_C);
    read_stat("R8 pass after rerun", 8'hF3, exp_stat(1, 0, 1));
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    read_stat("R7 protected bit7", 8'hF2, exp_stat(1, 0, 0));
    wp_n = 1'b1;
    read_stat("R7 unprotected bit7", 8'hF2, exp_stat(1, 0, 1));
  endtask

  task automatic t_persist();
    logic v;
    logic [7:0] d;
    send_cmd(8'hF3);
    for (int i = 0; i < 3; i++) begin
      strobe(v, d);
      chk("R10 repeated strobe valid", 32'(v), 32'(1));
      chk("R10 repeated strobe data", 32'(d), 32'(exp_stat(1, 0, 1)));
      wait_n(1);
    end
    send_cmd(8'h00);
    strobe(v, d);
    chk("R10 other command no data", 32'(v), 32'(0));
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_reject();
    t_concurrent();
    t_fail();
    t_wp();
    t_persist();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule